// File: doc/BRIEF.md
# Physical Register Rename Unit

This block renames architectural registers onto one shared pool of physical registers. Only tags move through the block; the register values stay in a separate physical register file. A map table records, for every architectural register, the physical register that currently holds its newest value, together with a ready bit. A FIFO free list holds the physical registers that are not allocated.

At dispatch the block does four things in the same cycle. It returns the physical tag and ready bit of each of the two source registers. It pops a fresh physical register for the destination. It reports the tag that the destination mapped to before, so the reorder buffer can keep it. At the clock edge it installs the fresh tag in the map. A completion broadcast of a physical tag sets the ready bit of the mapping that still holds that tag. When an instruction retires, the old tag it carried is pushed back onto the free list. A register is therefore reclaimed only when the next writer of the same architectural register retires.

The physical pool has `ARCH_REGS + ROB_ENTRIES` registers, and the free list never holds more than `ROB_ENTRIES` of them. Every architectural register always maps to some physical register.

Top module: `phys_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i with its ready bit set. The free list holds registers ARCH_REGS to ARCH_REGS+ROB_ENTRIES-1, with the lowest number at the head. Stall is low.
- R2: In every cycle, srcATag/srcAReady and srcBTag/srcBReady show the current map entry and ready bit of dispSrcA and dispSrcB, read combinationally.
- R3: oldTag shows the current mapping of dispDst. When a source names the same register as the destination, it returns the old mapping and not the newly allocated one.
- R4: newTag shows the free-list head. An accepted dispatch (dispValid high, stall low) pops it and, from the next cycle on, maps dispDst to it with the ready bit cleared.
- R5: stall is high exactly when the free list is empty. A dispatch attempted while stall is high changes neither the map nor the free list.
- R6: A completion with cmplTag sets the ready bit of any mapping that holds that tag. A completion whose tag is no longer in the map has no effect. A same-cycle dispatch to that register wins, and its new mapping stays not ready. Source ready bits reflect the state at the start of the cycle, with no same-cycle bypass.
- R7: retValid pushes retOldTag at the free-list tail. Tags are handed out in push order, after the tags already in the list.
- R8: A push and a pop in the same cycle leave the free-list occupancy unchanged. A push into an empty list while a dispatch waits keeps stall high in that cycle, and the pushed tag is offered in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispSrcA | input | $clog2(ARCH_REGS) | First source architectural register |
| dispSrcB | input | $clog2(ARCH_REGS) | Second source architectural register |
| dispDst | input | $clog2(ARCH_REGS) | Destination architectural register |
| stall | output | 1 | No physical register free; dispatch is not accepted |
| srcATag | output | $clog2(ARCH_REGS+ROB_ENTRIES) | Physical tag of first source |
| srcAReady | output | 1 | First source value is available |
| srcBTag | output | $clog2(ARCH_REGS+ROB_ENTRIES) | Physical tag of second source |
| srcBReady | output | 1 | Second source value is available |
| newTag | output | $clog2(ARCH_REGS+ROB_ENTRIES) | Physical register allocated to the destination |
| oldTag | output | $clog2(ARCH_REGS+ROB_ENTRIES) | Previous mapping of the destination |
| cmplValid | input | 1 | Completion broadcast valid |
| cmplTag | input | $clog2(ARCH_REGS+ROB_ENTRIES) | Physical tag that completed |
| retValid | input | 1 | Retirement of an instruction |
| retOldTag | input | $clog2(ARCH_REGS+ROB_ENTRIES) | Old tag to return to the free list |

## Verification
Some properties are checked on every cycle:
- after an accepted dispatch, the map holds the popped tag and that mapping is not ready;
- the free-list head does not move without a pop;
- a matching completion sets the ready bit unless a dispatch overwrote that entry;
- occupancy never rises above ROB_ENTRIES;
- a push paired with a pop leaves occupancy unchanged.

Other behaviours can only be shown by the bench's scenarios:
- the order in which recycled tags come back;
- that a stale completion leaves the map untouched;
- that a source naming the destination returns the old mapping;
- that a stalled dispatch leaves no trace;
- that a push into an empty list is offered one cycle later.

// File: rtl/rename_pkg.sv
package rename_pkg;
  typedef struct packed {
    logic pop;   // accepted dispatch: pop free list, write map
    logic push;  // retirement: push old tag onto free list
  } flStrobe_t;
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
#(
  parameter int ROB_ENTRIES = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      dispValid,
  input  logic      retValid,
  output logic      stall,
  output flStrobe_t strobes
);
  localparam int CW = $clog2(ROB_ENTRIES + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(ROB_ENTRIES);

  logic [CW-1:0] countQ;

  always_comb begin
    stall        = (countQ == '0);
    strobes.pop  = dispValid && !stall;
    strobes.push = retValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= CNT_FULL;
    end else begin
      case ({strobes.push, strobes.pop})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end

  // R7: a lone push must never overfill the free list
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && !strobes.pop) |-> (countQ < CNT_FULL));

  // R8: paired push and pop keep the occupancy
  assert_pair_keeps_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && strobes.pop) |=> (countQ == $past(countQ)));
endmodule

// File: rtl/rename_dp.sv
module rename_dp
  import rename_pkg::*;
#(
  parameter int ARCH_REGS   = 8,
  parameter int ROB_ENTRIES = 8
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  flStrobe_t                                   strobes,
  input  logic [$clog2(ARCH_REGS)-1:0]                dispSrcA,
  input  logic [$clog2(ARCH_REGS)-1:0]                dispSrcB,
  input  logic [$clog2(ARCH_REGS)-1:0]                dispDst,
  output logic [$clog2(ARCH_REGS+ROB_ENTRIES)-1:0]    srcATag,
  output logic                                        srcAReady,
  output logic [$clog2(ARCH_REGS+ROB_ENTRIES)-1:0]    srcBTag,
  output logic                                        srcBReady,
  output logic [$clog2(ARCH_REGS+ROB_ENTRIES)-1:0]    newTag,
  output logic [$clog2(ARCH_REGS+ROB_ENTRIES)-1:0]    oldTag,
  input  logic                                        cmplValid,
  input  logic [$clog2(ARCH_REGS+ROB_ENTRIES)-1:0]    cmplTag,
  input  logic [$clog2(ARCH_REGS+ROB_ENTRIES)-1:0]    retOldTag
);
  localparam int PHYS_REGS = ARCH_REGS + ROB_ENTRIES;
  localparam int TW        = $clog2(PHYS_REGS);
  localparam int PW        = (ROB_ENTRIES > 1) ? $clog2(ROB_ENTRIES) : 1;
  localparam logic [PW-1:0] PTR_LAST = PW'(ROB_ENTRIES - 1);

  logic [TW-1:0] mapQ   [ARCH_REGS];
  logic          readyQ [ARCH_REGS];
  logic [TW-1:0] freeQ  [ROB_ENTRIES];
  logic [PW-1:0] headQ, tailQ;

  always_comb begin
    srcATag   = mapQ[dispSrcA];
    srcAReady = readyQ[dispSrcA];
    srcBTag   = mapQ[dispSrcB];
    srcBReady = readyQ[dispSrcB];
    oldTag    = mapQ[dispDst];
    newTag    = freeQ[headQ];
  end

  // map table with per-entry ready bit
  generate
    for (genvar i = 0; i < ARCH_REGS; i++) begin : gMap
      always_ff @(posedge clk) begin
        if (!rstN) begin
          mapQ[i]   <= TW'(i);
          readyQ[i] <= 1'b1;
        end else if (strobes.pop && (dispDst == i)) begin
          mapQ[i]   <= newTag;
          readyQ[i] <= 1'b0;
        end else if (cmplValid && (mapQ[i] == cmplTag)) begin
          readyQ[i] <= 1'b1;
        end
      end

      // R6: a completion matching a surviving mapping sets its ready bit
      assert_cmpl_sets_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
        (cmplValid && (mapQ[i] == cmplTag) && !(strobes.pop && (dispDst == i)))
          |=> readyQ[i]);
    end
  endgenerate

  // free list FIFO storage
  generate
    for (genvar k = 0; k < ROB_ENTRIES; k++) begin : gFree
      always_ff @(posedge clk) begin
        if (!rstN)
          freeQ[k] <= TW'(ARCH_REGS + k);
        else if (strobes.push && (tailQ == k))
          freeQ[k] <= retOldTag;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
    end else begin
      if (strobes.pop)
        headQ <= (headQ == PTR_LAST) ? '0 : headQ + 1'b1;
      if (strobes.push)
        tailQ <= (tailQ == PTR_LAST) ? '0 : tailQ + 1'b1;
    end
  end

  // R4: accepted dispatch installs the popped tag, not ready
  assert_install_new_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |=> (mapQ[$past(dispDst)] == $past(newTag)));
  assert_new_not_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |=> !readyQ[$past(dispDst)]);

  // R5: without a pop the free-list head stays put
  assert_head_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pop |=> (headQ == $past(headQ)));
endmodule

// File: rtl/phys_rename.sv
module phys_rename
  import rename_pkg::*;
#(
  parameter int ARCH_REGS   = 8,
  parameter int ROB_ENTRIES = 8
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     dispValid,
  input  logic [$clog2(ARCH_REGS)-1:0]             dispSrcA,
  input  logic [$clog2(ARCH_REGS)-1:0]             dispSrcB,
  input  logic [$clog2(ARCH_REGS)-1:0]             dispDst,
  output logic                                     stall,
  output logic [$clog2(ARCH_REGS+ROB_ENTRIES)-1:0] srcATag,
  output logic                                     srcAReady,
  output logic [$clog2(ARCH_REGS+ROB_ENTRIES)-1:0] srcBTag,
  output logic                                     srcBReady,
  output logic [$clog2(ARCH_REGS+ROB_ENTRIES)-1:0] newTag,
  output logic [$clog2(ARCH_REGS+ROB_ENTRIES)-1:0] oldTag,
  input  logic                                     cmplValid,
  input  logic [$clog2(ARCH_REGS+ROB_ENTRIES)-1:0] cmplTag,
  input  logic                                     retValid,
  input  logic [$clog2(ARCH_REGS+ROB_ENTRIES)-1:0] retOldTag
);
  flStrobe_t strobes;

  rename_ctrl #(.ROB_ENTRIES(ROB_ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .retValid(retValid),
    .stall(stall), .strobes(strobes)
  );

  rename_dp #(.ARCH_REGS(ARCH_REGS), .ROB_ENTRIES(ROB_ENTRIES)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .dispSrcA(dispSrcA), .dispSrcB(dispSrcB), .dispDst(dispDst),
    .srcATag(srcATag), .srcAReady(srcAReady),
    .srcBTag(srcBTag), .srcBReady(srcBReady),
    .newTag(newTag), .oldTag(oldTag),
    .cmplValid(cmplValid), .cmplTag(cmplTag), .retOldTag(retOldTag)
  );
endmodule

// File: tb/sim_phys_rename.sv
module sim_phys_rename;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispValid = 1'b0;
  logic [2:0] dispSrcA = '0, dispSrcB = '0, dispDst = '0;
  logic cmplValid = 1'b0, retValid = 1'b0;
  logic [3:0] cmplTag = '0, retOldTag = '0;
  logic stall, srcAReady, srcBReady;
  logic [3:0] srcATag, srcBTag, newTag, oldTag;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phys_rename u0 (
    .clk(clk), .rstN(rstN), .dispValid(dispValid),
    .dispSrcA(dispSrcA), .dispSrcB(dispSrcB), .dispDst(dispDst),
    .stall(stall), .srcATag(srcATag), .srcAReady(srcAReady),
    .srcBTag(srcBTag), .srcBReady(srcBReady), .newTag(newTag), .oldTag(oldTag),
    .cmplValid(cmplValid), .cmplTag(cmplTag),
    .retValid(retValid), .retOldTag(retOldTag)
  );

  typedef struct packed {
    logic dv; logic [2:0] sa; logic [2:0] sb; logic [2:0] dst;
    logic cv; logic [3:0] ct; logic rv; logic [3:0] rt;
    logic [3:0] eA; logic eAr; logic [3:0] eB; logic eBr;
    logic [3:0] eN; logic [3:0] eO; logic eS;
  } vec_t;

  // Expectations derived from R1..R8 starting at the reset state
  localparam vec_t VECS [8] = '{
    // R2 R4: plain dispatch, first pop is 8
    '{1'b1, 3'd1, 3'd2, 3'd3, 1'b0, 4'd0, 1'b0, 4'd0, 4'd1, 1'b1, 4'd2, 1'b1, 4'd8, 4'd3, 1'b0},
    // R3: sources naming the destination see the old mapping 8
    '{1'b1, 3'd3, 3'd3, 3'd3, 1'b0, 4'd0, 1'b0, 4'd0, 4'd8, 1'b0, 4'd8, 1'b0, 4'd9, 4'd8, 1'b0},
    // R6: stale completion of tag 8
    '{1'b0, 3'd3, 3'd3, 3'd3, 1'b1, 4'd8, 1'b0, 4'd0, 4'd9, 1'b0, 4'd9, 1'b0, 4'd10, 4'd9, 1'b0},
    // R6: stale completion had no effect; now complete 9, no bypass
    '{1'b0, 3'd3, 3'd0, 3'd3, 1'b1, 4'd9, 1'b0, 4'd0, 4'd9, 1'b0, 4'd0, 1'b1, 4'd10, 4'd9, 1'b0},
    // R6 R7: ready set by completion; retire pushes tag 3
    '{1'b0, 3'd3, 3'd0, 3'd0, 1'b0, 4'd0, 1'b1, 4'd3, 4'd9, 1'b1, 4'd0, 1'b1, 4'd10, 4'd0, 1'b0},
    // R8: push 8 and pop 10 together
    '{1'b1, 3'd0, 3'd3, 3'd0, 1'b0, 4'd0, 1'b1, 4'd8, 4'd0, 1'b1, 4'd9, 1'b1, 4'd10, 4'd0, 1'b0},
    // R6: dispatch to r0 wins over completion of its old tag 10
    '{1'b1, 3'd0, 3'd3, 3'd0, 1'b1, 4'd10, 1'b0, 4'd0, 4'd10, 1'b0, 4'd9, 1'b1, 4'd11, 4'd10, 1'b0},
    // R6: r0 now holds 11, not ready
    '{1'b0, 3'd0, 3'd3, 3'd0, 1'b0, 4'd0, 1'b0, 4'd0, 4'd11, 1'b0, 4'd9, 1'b1, 4'd12, 4'd11, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    dispValid = 1'b0; cmplValid = 1'b0; retValid = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state
    #1;
    check("R1 stall", stall, 0);
    check("R1 head", newTag, 8);
    for (int i = 0; i < 8; i++) begin
      dispSrcA = 3'(i); #1;
      check("R1 map", srcATag, i);
      check("R1 ready", srcAReady, 1);
    end

    // table walk
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      dispValid = VECS[v].dv; dispSrcA = VECS[v].sa; dispSrcB = VECS[v].sb;
      dispDst = VECS[v].dst; cmplValid = VECS[v].cv; cmplTag = VECS[v].ct;
      retValid = VECS[v].rv; retOldTag = VECS[v].rt;
      #1;
      check("R2 srcA tag", srcATag, VECS[v].eA);
      check("R2 srcA ready", srcAReady, VECS[v].eAr);
      check("R2 srcB tag", srcBTag, VECS[v].eB);
      check("R2 srcB ready", srcBReady, VECS[v].eBr);
      check("R4 newTag", newTag, VECS[v].eN);
      check("R3 oldTag", oldTag, VECS[v].eO);
      check("R5 stall", stall, VECS[v].eS);
    end

    // R7: drain the free list; recycled 3 and 8 follow 12..15
    begin
      int order [6] = '{12, 13, 14, 15, 3, 8};
      for (int n = 0; n < 6; n++) begin
        @(negedge clk); idle();
        dispValid = 1'b1; dispDst = 3'd1; dispSrcA = 3'd1;
        #1;
        check("R7 pop order", newTag, order[n]);
        check("R5 not stalled", stall, 0);
      end
    end

    // R5: empty list stalls; a stalled dispatch leaves the map alone
    @(negedge clk); idle(); dispValid = 1'b1; dispDst = 3'd1; dispSrcA = 3'd1;
    #1;
    check("R5 stall empty", stall, 1);
    check("R5 map r1", srcATag, 8);
    @(negedge clk); #1;
    check("R5 map unchanged", srcATag, 8);
    check("R5 still stalled", stall, 1);

    // R8: push into empty list with waiting dispatch
    @(negedge clk); retValid = 1'b1; retOldTag = 4'd11; dispValid = 1'b1;
    #1;
    check("R8 stall same cycle", stall, 1);
    @(negedge clk); retValid = 1'b0; dispValid = 1'b1; dispDst = 3'd1;
    #1;
    check("R8 stall released", stall, 0);
    check("R8 pushed tag offered", newTag, 11);
    @(negedge clk); idle(); dispSrcA = 3'd1;
    #1;
    check("R8 map got 11", srcATag, 11);
    check("R5 empty again", stall, 1);

    finish_run();
  end
endmodule